// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block takes the divider settings of a frequency synthesizer over a three-wire serial link. The link carries a serial clock, a data line and an active-low load-enable line. A steering line picks which of two shift registers the incoming bits go to. The block runs on a system clock. Every serial-side pin passes through a synchronizer, and the edges of the serial clock and of both strobes are detected in the system-clock domain.

When steering is low, bits go into a 21-bit primary shift register. When it is high, they go into an 8-bit enhancement register. The primary register is double-buffered. A rising edge on the load-enable line, or on a separate hop strobe, copies the whole primary word into a holding register in a single cycle, and that holding register feeds the divider outputs.

A direct-mode input bypasses the serial path, so the divider values come from parallel hard-wired inputs instead. An enhancement-enable input, active low, decides whether the enhancement bits reach their output or read as zero.

Top module: `scfg_serial_port`

## Requirements
- R1: After synchronous reset, the holding register and the enhancement register are all zeros. With direct mode low and enhancement enable low, `m_cnt`, `a_cnt`, `r_cnt` and `enh_q` all read zero.
- R2: Data is sampled on each rising edge of `sclk`, most-significant bit first. The primary word is laid out as follows: bits 20..12 carry M, bits 11..8 carry A, bits 7..2 carry R, and bits 1..0 are ignored.
- R3: While `enh_sel` is high, bits shift into the enhancement register, and the primary register is left untouched.
- R4: Rising edges of `sclk` that arrive while `load_n` is high change neither shift register.
- R5: A rising edge of `load_n` copies the primary register into the holding register.
- R6: A rising edge of `hop_wr` also copies the primary register into the holding register, even while `load_n` stays low.
- R7: The serial-path outputs stay unchanged while a new primary word is being shifted in. They change only after a strobe edge.
- R8: While `direct_mode` is high, `m_cnt`, `a_cnt` and `r_cnt` follow `m_par`, `a_par` and `r_par`. While it is low, they show the holding register again.
- R9: `enh_q` shows the enhancement register while `enh_en_n` is low, and reads zero while `enh_en_n` is high.
- R10: The enhancement register keeps only the last 8 bits shifted into it. Longer bursts push the earlier bits out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Shifting allowed while low; rising edge transfers the primary word |
| enh_sel | input | 1 | Steering: low selects the primary register, high selects the enhancement register |
| hop_wr | input | 1 | Rising edge transfers the primary word |
| direct_mode | input | 1 | High selects the parallel divider inputs |
| enh_en_n | input | 1 | Low lets the enhancement bits through |
| m_par | input | 9 | Parallel M value |
| a_par | input | 4 | Parallel A value |
| r_par | input | 6 | Parallel R value |
| m_cnt | output | 9 | M divider setting |
| a_cnt | output | 4 | A divider setting |
| r_cnt | output | 6 | R divider setting |
| enh_q | output | 8 | Gated enhancement bits |

## Verification
Three full 21-bit words with distinct, asymmetric field values are sent. This shows whether the bit order and the field boundaries are right, and whether the two ignored bits leak into R. One word is sent without a strobe and then transferred by the hop strobe, which separates double buffering from a direct pass-through and separates the two transfer paths. A 12-bit burst into the enhancement register, followed by a load edge, shows whether the steering isolates the primary word and whether the register truncates to its last 8 bits. Words clocked in with load-enable high, and parallel values applied with direct mode set, show whether blocked edges are really ignored and whether the bypass overrides the held word and then hands control back to it.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int PRI_W = 21;
    localparam int ENH_W = 8;
    localparam int M_W   = 9;
    localparam int A_W   = 4;
    localparam int R_W   = 6;

    localparam int M_LSB = 12;
    localparam int A_LSB = 8;
    localparam int R_LSB = 2;

    localparam int PIN_W = 5;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic [R_W-1:0] r;
    } div_cfg_t;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic load_n;
        logic sel;
        logic hop;
    } pin_set_t;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_PRI  = 2'd1,
        DST_ENH  = 2'd2
    } shift_dst_t;

    function automatic div_cfg_t unpack_pri(input logic [PRI_W-1:0] w);
        div_cfg_t c;
        c.m = w[M_LSB +: M_W];
        c.a = w[A_LSB +: A_W];
        c.r = w[R_LSB +: R_W];
        return c;
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scfg_rise.sv
module scfg_rise #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~prev[i];
    end
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/scfg_hold.sv
module scfg_hold #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/scfg_serial_port.sv
module scfg_serial_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk,
    input  logic           sdata,
    input  logic           load_n,
    input  logic           enh_sel,
    input  logic           hop_wr,
    input  logic           direct_mode,
    input  logic           enh_en_n,
    input  logic [M_W-1:0] m_par,
    input  logic [A_W-1:0] a_par,
    input  logic [R_W-1:0] r_par,
    output logic [M_W-1:0] m_cnt,
    output logic [A_W-1:0] a_cnt,
    output logic [R_W-1:0] r_cnt,
    output logic [ENH_W-1:0] enh_q
);
    localparam int EDGE_W = 3;

    pin_set_t   raw_pins;
    pin_set_t   syn_pins;
    logic [PIN_W-1:0] syn_bits;
    logic [EDGE_W-1:0] edge_lvl;
    logic [EDGE_W-1:0] edge_rise;

    logic       load_s;
    logic       sel_s;
    logic       sclk_rise;
    logic       shift_go;
    logic       xfer;
    shift_dst_t dst;

    logic [PRI_W-1:0] pri_q;
    logic [PRI_W-1:0] sec_q;
    logic [ENH_W-1:0] enh_raw;

    div_cfg_t sec_cfg;
    div_cfg_t par_cfg;
    div_cfg_t sel_cfg;
    div_cfg_t out_cfg;

    always_comb begin
        raw_pins.sclk   = sclk;
        raw_pins.sdata  = sdata;
        raw_pins.load_n = load_n;
        raw_pins.sel    = enh_sel;
        raw_pins.hop    = hop_wr;
    end

    scfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_bits)
    );

    assign syn_pins = pin_set_t'(syn_bits);
    assign load_s   = syn_pins.load_n;
    assign sel_s    = syn_pins.sel;
    assign edge_lvl = {syn_pins.sclk, syn_pins.load_n, syn_pins.hop};

    scfg_rise #(.W(EDGE_W)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (edge_lvl),
        .rise (edge_rise)
    );

    assign sclk_rise = edge_rise[2];
    assign xfer      = edge_rise[1] | edge_rise[0];
    assign shift_go  = sclk_rise & ~load_s;

    always_comb begin
        if (!shift_go)  dst = DST_NONE;
        else if (sel_s) dst = DST_ENH;
        else            dst = DST_PRI;
    end

    scfg_shifter #(.W(PRI_W)) u_pri (
        .clk (clk),
        .rst (rst),
        .en  (dst == DST_PRI),
        .din (syn_pins.sdata),
        .q   (pri_q)
    );

    scfg_shifter #(.W(ENH_W)) u_enh (
        .clk (clk),
        .rst (rst),
        .en  (dst == DST_ENH),
        .din (syn_pins.sdata),
        .q   (enh_raw)
    );

    scfg_hold #(.W(PRI_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (xfer),
        .d    (pri_q),
        .q    (sec_q)
    );

    always_comb begin
        sec_cfg   = unpack_pri(sec_q);
        par_cfg.m = m_par;
        par_cfg.a = a_par;
        par_cfg.r = r_par;
        sel_cfg   = direct_mode ? par_cfg : sec_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cfg <= '0;
            enh_q   <= '0;
        end else begin
            out_cfg <= sel_cfg;
            enh_q   <= enh_en_n ? '0 : enh_raw;
        end
    end

    assign m_cnt = out_cfg.m;
    assign a_cnt = out_cfg.a;
    assign r_cnt = out_cfg.r;
endmodule

// File: rtl/scfg_serial_port_chk.sv
module scfg_serial_port_chk
    import scfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load_s,
    input logic             sel_s,
    input logic             shift_go,
    input logic             xfer,
    input logic [PRI_W-1:0] pri_q,
    input logic [PRI_W-1:0] sec_q,
    input logic [ENH_W-1:0] enh_raw,
    input logic             direct_mode,
    input logic             enh_en_n,
    input logic [M_W-1:0]   m_par,
    input logic [A_W-1:0]   a_par,
    input logic [R_W-1:0]   r_par,
    input logic [M_W-1:0]   m_cnt,
    input logic [A_W-1:0]   a_cnt,
    input logic [R_W-1:0]   r_cnt,
    input logic [ENH_W-1:0] enh_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sec_q == '0 && enh_raw == '0 && enh_q == '0));

    a_r3_sel_keeps_pri: assert property (@(posedge clk) disable iff (rst)
        (shift_go && sel_s) |=> $stable(pri_q));

    a_r4_blocked_shift: assert property (@(posedge clk) disable iff (rst)
        load_s |=> ($stable(pri_q) && $stable(enh_raw)));

    a_r5_xfer_copies: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (sec_q == $past(pri_q)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(sec_q));

    a_r8_direct_follow: assert property (@(posedge clk) disable iff (rst)
        direct_mode |=> (m_cnt == $past(m_par) && a_cnt == $past(a_par)
                         && r_cnt == $past(r_par)));

    a_r9_enh_gated: assert property (@(posedge clk) disable iff (rst)
        enh_en_n |=> (enh_q == '0));
endmodule

bind scfg_serial_port scfg_serial_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_s      (load_s),
    .sel_s       (sel_s),
    .shift_go    (shift_go),
    .xfer        (xfer),
    .pri_q       (pri_q),
    .sec_q       (sec_q),
    .enh_raw     (enh_raw),
    .direct_mode (direct_mode),
    .enh_en_n    (enh_en_n),
    .m_par       (m_par),
    .a_par       (a_par),
    .r_par       (r_par),
    .m_cnt       (m_cnt),
    .a_cnt       (a_cnt),
    .r_cnt       (r_cnt),
    .enh_q       (enh_q)
);

// File: tb/tb_scfg_serial_port.sv
module tb_scfg_serial_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic       load_n = 1'b1;
    logic       enh_sel = 1'b0;
    logic       hop_wr = 1'b0;
    logic       direct_mode = 1'b0;
    logic       enh_en_n = 1'b0;
    logic [8:0] m_par = '0;
    logic [3:0] a_par = '0;
    logic [5:0] r_par = '0;
    logic [8:0] m_cnt;
    logic [3:0] a_cnt;
    logic [5:0] r_cnt;
    logic [7:0] enh_q;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    scfg_serial_port dut (
        .clk (clk), .rst (rst), .sclk (sclk), .sdata (sdata),
        .load_n (load_n), .enh_sel (enh_sel), .hop_wr (hop_wr),
        .direct_mode (direct_mode), .enh_en_n (enh_en_n),
        .m_par (m_par), .a_par (a_par), .r_par (r_par),
        .m_cnt (m_cnt), .a_cnt (a_cnt), .r_cnt (r_cnt), .enh_q (enh_q)
    );

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] mk_word(input logic [8:0] m, input logic [3:0] a,
                                            input logic [5:0] r, input logic [1:0] pad);
        return {m, a, r, pad};
    endfunction

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sdata = v[i];
            wait_clks(4);
            sclk = 1'b1;
            wait_clks(4);
            sclk = 1'b0;
        end
        wait_clks(4);
    endtask

    task automatic check_cnt(input string req, input logic [8:0] m,
                             input logic [3:0] a, input logic [5:0] r);
        check({req, " M"}, int'(m_cnt), int'(m));
        check({req, " A"}, int'(a_cnt), int'(a));
        check({req, " R"}, int'(r_cnt), int'(r));
    endtask

    // R1: reset state
    task automatic t_reset;
        check_cnt("R1", 9'd0, 4'd0, 6'd0);
        check("R1 enh", int'(enh_q), 0);
    endtask

    // R2 + R5: full word then load edge
    task automatic t_serial_load;
        @(negedge clk); load_n = 1'b0;
        wait_clks(4);
        send_bits({11'd0, mk_word(9'h1A5, 4'h9, 6'h2D, 2'b11)}, 21);
        load_n = 1'b1;
        wait_clks(8);
        check_cnt("R2 R5", 9'h1A5, 4'h9, 6'h2D);
    endtask

    // R7 + R6: shift without strobe, then hop
    task automatic t_hop_buffer;
        @(negedge clk); load_n = 1'b0;
        wait_clks(4);
        send_bits({11'd0, mk_word(9'h0F3, 4'h5, 6'h11, 2'b10)}, 21);
        wait_clks(8);
        check_cnt("R7", 9'h1A5, 4'h9, 6'h2D);
        hop_wr = 1'b1;
        wait_clks(5);
        hop_wr = 1'b0;
        wait_clks(6);
        check_cnt("R6", 9'h0F3, 4'h5, 6'h11);
        load_n = 1'b1;
        wait_clks(8);
    endtask

    // R3, R10, R9: enhancement path
    task automatic t_enh;
        @(negedge clk); enh_sel = 1'b1; load_n = 1'b0;
        wait_clks(4);
        send_bits(32'h0000_0ABC, 12);
        enh_sel = 1'b0;
        wait_clks(4);
        load_n = 1'b1;
        wait_clks(8);
        check("R10 enh last 8", int'(enh_q), 8'hBC);
        check_cnt("R3", 9'h0F3, 4'h5, 6'h11);
        enh_en_n = 1'b1;
        wait_clks(4);
        check("R9 gated", int'(enh_q), 0);
        enh_en_n = 1'b0;
        wait_clks(4);
        check("R9 open", int'(enh_q), 8'hBC);
    endtask

    // R4: edges with load_n high do nothing
    task automatic t_load_high;
        @(negedge clk); load_n = 1'b1;
        send_bits({11'd0, mk_word(9'h155, 4'hC, 6'h3A, 2'b01)}, 21);
        enh_sel = 1'b1;
        wait_clks(4);
        send_bits(32'h0000_0042, 8);
        enh_sel = 1'b0;
        wait_clks(4);
        load_n = 1'b0;
        wait_clks(6);
        load_n = 1'b1;
        wait_clks(8);
        check_cnt("R4", 9'h0F3, 4'h5, 6'h11);
        check("R4 enh", int'(enh_q), 8'hBC);
    endtask

    // R8: direct bypass and return
    task automatic t_direct;
        @(negedge clk);
        m_par = 9'h1C3; a_par = 4'hE; r_par = 6'h07;
        direct_mode = 1'b1;
        wait_clks(3);
        check_cnt("R8 direct", 9'h1C3, 4'hE, 6'h07);
        m_par = 9'h02A; a_par = 4'h1; r_par = 6'h30;
        wait_clks(3);
        check_cnt("R8 direct2", 9'h02A, 4'h1, 6'h30);
        direct_mode = 1'b0;
        wait_clks(3);
        check_cnt("R8 serial", 9'h0F3, 4'h5, 6'h11);
    endtask

    initial begin
        #1_500_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(8);
        t_reset();
        t_serial_load();
        t_hop_buffer();
        t_enh();
        t_load_high();
        t_direct();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule